// File: doc/BRIEF.md
# Burst Column Address Generator

This block walks a memory burst beat by beat and supplies the column address for each beat. When a column command is accepted, the block captures the start column and the burst mode: a length code and an ordering bit. From the next cycle on, it presents one address per clock. It raises a beat-valid flag while a burst is running and a last-beat flag on the final beat of a burst that has a fixed length.

Fixed-length bursts stay inside a block that is aligned to the burst length. Only the low bits step, either counting upward or following an XOR pattern. A full-page burst runs over the whole column space and keeps wrapping until a terminate pulse or a new command ends it. The mode inputs are treated as static apart from the command cycle.

The output is a stream with no back-pressure: beats advance on every clock, because a memory data phase cannot stall. For that reason there is no ready input. The column width `COL_W` must be at least 3.

Top module: `burst_colgen`

## Requirements
- R1: After reset, beat_valid, beat_last and mode_err are low.
- R2: In the cycle after cmd_valid is high, beat_valid is high and col_addr equals the start_col captured with the command.
- R3: The burst length is set by len_code: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives full page. Any other code behaves as length 1.
- R4: With ilv_order low (sequential), beat k carries low log2(BL) bits equal to (start + k) mod BL.
- R5: With ilv_order high (interleaved), beat k carries low bits equal to start XOR k. For BL 8 and start 2 the order is 2, 3, 0, 1, 6, 7, 4, 5.
- R6: During a fixed-length burst, the column bits above the low log2(BL) bits hold the start value.
- R7: A length-1 burst gives exactly one beat, and beat_last is high on that beat.
- R8: Bursts of 2, 4 and 8 give exactly BL beats. beat_last is high only on the final beat, and beat_valid is low in the cycle after it.
- R9: A full-page burst steps the whole column address by one each beat and wraps from all ones to zero. It never raises beat_last and never ends on its own.
- R10: If term is high in a cycle where a beat is shown and no command is present, that beat is the last one and beat_valid is low in the next cycle.
- R11: A command during an active burst cancels that burst, and the new burst's first beat appears in the next cycle. A command takes priority over term in the same cycle.
- R12: A full-page code together with ilv_order high runs sequentially. mode_err is high from the cycle after that command until the cycle after the next command; any other command clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Column command accepted this cycle |
| start_col | input | COL_W | First column of the burst |
| len_code | input | 3 | Burst length code |
| ilv_order | input | 1 | 1 selects interleaved order, 0 selects sequential |
| term | input | 1 | Ends the running burst after the current beat |
| col_addr | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | A beat is being presented |
| beat_last | output | 1 | Final beat of a fixed-length burst |
| mode_err | output | 1 | Last command asked for interleaved full page |

## Verification
The bench builds the block with COL_W = 5, which makes a full page 32 columns. This small page lets it sweep every start column under every fixed length and both orders, and compare each beat against an address computed arithmetically in the bench. The small page also lets a full-page burst pass its wrap point and go more than twice around within a few dozen cycles. It also exercises the cancel-with-terminate race, the interleaved full-page error and a reserved length code.

// File: rtl/burst_colgen_pkg.sv
package burst_colgen_pkg;

  localparam logic [2:0] LEN_1    = 3'b000;
  localparam logic [2:0] LEN_2    = 3'b001;
  localparam logic [2:0] LEN_4    = 3'b010;
  localparam logic [2:0] LEN_8    = 3'b011;
  localparam logic [2:0] LEN_PAGE = 3'b111;

  typedef struct packed {
    logic       full;   // whole-page burst
    logic       ilv;    // effective interleave after legality fix-up
    logic       err;    // interleave requested with full page
    logic [2:0] lg2;    // log2 of fixed burst length
  } mode_cfg_t;

endpackage

// File: rtl/burst_colgen_mode.sv
module burst_colgen_mode
  import burst_colgen_pkg::*;
(
  input  logic [2:0] len_code,
  input  logic       ilv_order,
  output mode_cfg_t  cfg
);

  always_comb begin
    cfg = '0;
    unique case (len_code)
      LEN_2:    cfg.lg2 = 3'd1;
      LEN_4:    cfg.lg2 = 3'd2;
      LEN_8:    cfg.lg2 = 3'd3;
      LEN_PAGE: cfg.full = 1'b1;
      default:  cfg.lg2 = 3'd0;
    endcase
    cfg.ilv = ilv_order & ~cfg.full;
    cfg.err = ilv_order & cfg.full;
  end

endmodule

// File: rtl/burst_colgen_seq.sv
module burst_colgen_seq
  import burst_colgen_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [COL_W-1:0] start_col,
  input  mode_cfg_t        cfg,
  input  logic             term,
  output logic             active,
  output logic [COL_W-1:0] base,
  output logic [COL_W-1:0] cnt,
  output logic [COL_W-1:0] mask,
  output logic             ilv,
  output logic             err,
  output logic             last
);

  logic [COL_W-1:0] mask_d;
  logic             full_q;

  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign mask_d[i] = cfg.full | (int'(cfg.lg2) > i);
  end

  assign last = active & ~full_q & (cnt == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= '0;
      cnt    <= '0;
      mask   <= '0;
      ilv    <= 1'b0;
      full_q <= 1'b0;
      err    <= 1'b0;
    end else if (cmd_valid) begin
      active <= 1'b1;
      base   <= start_col;
      cnt    <= '0;
      mask   <= mask_d;
      ilv    <= cfg.ilv;
      full_q <= cfg.full;
      err    <= cfg.err;
    end else if (active) begin
      if (term || last) active <= 1'b0;
      else              cnt    <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/burst_colgen_addr.sv
module burst_colgen_addr #(
  parameter int unsigned COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] cnt,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] low;

  assign low = ilv ? (base ^ cnt) : (base + cnt);

  for (genvar i = 0; i < COL_W; i++) begin : g_merge
    assign col[i] = mask[i] ? low[i] : base[i];
  end

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
  import burst_colgen_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             ilv_order,
  input  logic             term,
  output logic [COL_W-1:0] col_addr,
  output logic             beat_valid,
  output logic             beat_last,
  output logic             mode_err
);

  mode_cfg_t        cfg;
  logic [COL_W-1:0] base, cnt, mask;
  logic             ilv;

  burst_colgen_mode u_mode (
    .len_code  (len_code),
    .ilv_order (ilv_order),
    .cfg       (cfg)
  );

  burst_colgen_seq #(.COL_W(COL_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .start_col (start_col),
    .cfg       (cfg),
    .term      (term),
    .active    (beat_valid),
    .base      (base),
    .cnt       (cnt),
    .mask      (mask),
    .ilv       (ilv),
    .err       (mode_err),
    .last      (beat_last)
  );

  burst_colgen_addr #(.COL_W(COL_W)) u_addr (
    .base (base),
    .cnt  (cnt),
    .mask (mask),
    .ilv  (ilv),
    .col  (col_addr)
  );

endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk #(
  parameter int unsigned COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [COL_W-1:0] start_col,
  input logic [2:0]       len_code,
  input logic             ilv_order,
  input logic             term,
  input logic [COL_W-1:0] col_addr,
  input logic             beat_valid,
  input logic             beat_last,
  input logic             mode_err
);

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !beat_valid && !beat_last && !mode_err);

  a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> beat_valid && col_addr == $past(start_col));

  a_r6_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && $past(beat_valid) && !$past(cmd_valid) && $past(len_code) != 3'b111
    |-> col_addr[COL_W-1:3] == $past(col_addr[COL_W-1:3]));

  a_r7_single_last: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_valid) && $past(len_code) == 3'b000 |-> beat_valid && beat_last);

  a_r8_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last && !cmd_valid |=> !beat_valid);

  a_r9_page_step: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && $past(beat_valid) && !$past(cmd_valid) && !$past(term)
      && $past(len_code) == 3'b111
    |-> !beat_last && col_addr == COL_W'($past(col_addr) + 1'b1));

  a_r10_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && term && !cmd_valid |=> !beat_valid);

  a_r12_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> mode_err == ($past(len_code) == 3'b111 && $past(ilv_order)));

endmodule

bind burst_colgen burst_colgen_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/burst_colgen_tb.sv
module burst_colgen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 5;
  localparam int PAGE = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0]       len_code = 3'b000;
  logic             ilv_order = 1'b0;
  logic             term = 1'b0;
  logic [COL_W-1:0] col_addr;
  logic             beat_valid, beat_last, mode_err;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_colgen #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .start_col(start_col),
    .len_code(len_code), .ilv_order(ilv_order), .term(term),
    .col_addr(col_addr), .beat_valid(beat_valid), .beat_last(beat_last),
    .mode_err(mode_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_addr(input int s, input int lg, input bit full,
                                  input bit ilv, input int k);
    int m, lo;
    m  = full ? PAGE - 1 : (1 << lg) - 1;
    lo = (ilv && !full) ? (s ^ k) : (s + k);
    return ((s & ~m) | (lo & m)) & (PAGE - 1);
  endfunction

  task automatic issue(input logic [2:0] code, input bit ilv, input int s);
    @(negedge clk);
    len_code  = code;
    ilv_order = ilv;
    start_col = COL_W'(s);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Runs a fixed-length burst and checks every beat, then the idle cycle.
  task automatic fixed_burst(input logic [2:0] code, input int lg, input bit ilv, input int s);
    int n;
    n = 1 << lg;
    issue(code, ilv, s);
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      chk("R2/R4/R5/R6 valid", int'(beat_valid), 1);
      chk(ilv ? "R5/R6 addr" : "R4/R6 addr", int'(col_addr), exp_addr(s, lg, 1'b0, ilv, k));
      chk(lg == 0 ? "R7 last" : "R8 last", int'(beat_last), (k == n - 1) ? 1 : 0);
      chk("R12 err clear", int'(mode_err), 0);
    end
    @(negedge clk);
    chk(lg == 0 ? "R7 end" : "R8 end", int'(beat_valid), 0);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", int'(beat_valid), 0);
    chk("R1 last", int'(beat_last), 0);
    chk("R1 err", int'(mode_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle", int'(beat_valid), 0);

    // R3 R4 R5 R6 R7 R8: every fixed length, both orders, every start column
    for (int lg = 0; lg < 4; lg++)
      for (int o = 0; o < 2; o++)
        for (int s = 0; s < PAGE; s++)
          fixed_burst(3'(lg), lg, o[0], s);

    // R3: reserved code acts as length 1
    fixed_burst(3'b101, 0, 1'b0, 19);
    fixed_burst(3'b100, 0, 1'b1, 7);

    // R5: documented interleave example
    issue(3'b011, 1'b1, 2);
    begin
      int ord[8] = '{2, 3, 0, 1, 6, 7, 4, 5};
      for (int k = 0; k < 8; k++) begin
        if (k > 0) @(negedge clk);
        chk("R5 example order", int'(col_addr), ord[k]);
      end
    end
    @(negedge clk);

    // R9 R10: full page wraps past all ones, then terminate
    issue(3'b111, 1'b0, 30);
    for (int k = 0; k < 70; k++) begin
      if (k > 0) @(negedge clk);
      chk("R9 page addr", int'(col_addr), (30 + k) % PAGE);
      chk("R9 no last", int'(beat_last), 0);
      chk("R9 valid", int'(beat_valid), 1);
    end
    term = 1'b1;
    @(negedge clk);
    term = 1'b0;
    chk("R10 term", int'(beat_valid), 0);
    @(negedge clk);
    chk("R10 stays idle", int'(beat_valid), 0);

    // R12: interleaved full page runs sequentially and flags
    issue(3'b111, 1'b1, 6);
    for (int k = 0; k < 12; k++) begin
      if (k > 0) @(negedge clk);
      chk("R12 seq addr", int'(col_addr), exp_addr(6, 0, 1'b1, 1'b0, k));
      chk("R12 err", int'(mode_err), 1);
    end
    term = 1'b1;
    @(negedge clk);
    term = 1'b0;
    chk("R12 err held", int'(mode_err), 1);
    issue(3'b001, 1'b0, 9);
    chk("R12 err cleared", int'(mode_err), 0);
    chk("R12 next addr", int'(col_addr), 9);
    @(negedge clk);
    chk("R12 next addr2", int'(col_addr), 8);
    @(negedge clk);

    // R11: new command with term mid-burst
    issue(3'b011, 1'b0, 5);
    @(negedge clk);
    @(negedge clk);
    chk("R11 old beat", int'(col_addr), 7);
    len_code  = 3'b010;
    ilv_order = 1'b1;
    start_col = COL_W'(13);
    cmd_valid = 1'b1;
    term      = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    term      = 1'b0;
    begin
      int ord4[4] = '{13, 12, 15, 14};
      for (int k = 0; k < 4; k++) begin
        if (k > 0) @(negedge clk);
        chk("R11 new addr", int'(col_addr), ord4[k]);
        chk("R11 new valid", int'(beat_valid), 1);
        chk("R11 new last", int'(beat_last), k == 3 ? 1 : 0);
      end
    end
    @(negedge clk);
    chk("R11 end", int'(beat_valid), 0);

    report();
  end

endmodule